// File: doc/BRIEF.md
# Periodic ALIGN Inserter and Stripper

This block sits between a serial link's framing logic and its PHY. On the transmit side it takes a 32-bit dword stream from upstream under a valid/ready handshake and sends it to the PHY unchanged. After a programmable number of data dwords it inserts a group of ALIGN primitives. While the group goes out, upstream is held off. On the receive side every ALIGN primitive is removed from the incoming stream, and all other dwords pass through with one cycle of latency.

The interval is normally 254 data dwords, with groups of two ALIGNs. For diagnostics the interval can be cut down to a single data dword, which gives the pattern ALIGN, ALIGN, data, ALIGN, ALIGN. A mode input widens each group to four ALIGNs. An ALIGN is the dword 0x7B4A4ABC with the control-character flag set. The PHY side has no backpressure. Configuration is expected to be held steady while traffic runs.

Top module: `align_pacer`

## Requirements
- R1: After reset, tx_out_valid and rx_out_valid are low and tx_in_ready is high.
- R2: A dword accepted on the transmit input (valid and ready high at a clock edge) appears on tx_out, with its data and its control flag unchanged, in the next cycle.
- R3: After every cfg_gap accepted non-ALIGN dwords, an ALIGN group follows immediately on tx_out. An ALIGN is data 0x7B4A4ABC with the control flag set.
- R4: A group holds 2 ALIGNs when cfg_quad is 0 and 4 ALIGNs when cfg_quad is 1. The ALIGNs of a group go out on consecutive cycles and are never split by data.
- R5: tx_in_ready is low in exactly the cycles in which the block is emitting a group, and high otherwise.
- R6: In a cycle with no accepted input outside a group, tx_out_valid is low in the next cycle, and the interval count does not advance.
- R7: An upstream dword that is itself an ALIGN is passed on to tx_out but does not count toward the interval.
- R8: On the receive path, a valid dword that has data 0x7B4A4ABC and the control flag set never appears on rx_out.
- R9: Every other valid receive dword (a control dword with a different value, or the ALIGN value without the flag) appears on rx_out, in order, one cycle after it arrives.
- R10: A cfg_gap of 0 behaves exactly like a cfg_gap of 1.
- R11: When the transmit output is looped back into the receive input, the receive output carries every upstream data dword, in order, with none lost or added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_gap | input | 8 | Data dwords between ALIGN groups (0 acts as 1) |
| cfg_quad | input | 1 | 1 selects four ALIGNs per group, 0 selects two |
| tx_in_data | input | 32 | Upstream dword |
| tx_in_k | input | 1 | Upstream control-character flag |
| tx_in_valid | input | 1 | Upstream dword valid |
| tx_in_ready | output | 1 | Block accepts the upstream dword |
| tx_out_data | output | 32 | Dword to PHY |
| tx_out_k | output | 1 | Control flag to PHY |
| tx_out_valid | output | 1 | Dword to PHY valid |
| rx_in_data | input | 32 | Dword from PHY |
| rx_in_k | input | 1 | Control flag from PHY |
| rx_in_valid | input | 1 | Dword from PHY valid |
| rx_out_data | output | 32 | Received dword with ALIGNs removed |
| rx_out_k | output | 1 | Received control flag |
| rx_out_valid | output | 1 | Received dword valid |

## Verification
The group-length assertions assume that cfg_quad stays constant from reset until the check, because they compare the length of each ready-low run with the current mode. The stimulus therefore sets cfg_gap and cfg_quad only while reset is high and keeps them fixed for the rest of each run. The receive assertions assume that rx_in_valid, rx_in_k and rx_in_data hold known values. The bench always drives them, either from its own registers or from the looped-back transmit output. The transmit-side assertions assume nothing about upstream timing, and the stimulus mixes continuous streaming with idle gaps.

// File: rtl/align_pacer_pkg.sv
package align_pacer_pkg;
  localparam int DW = 32;
  localparam logic [DW-1:0] ALIGN_WORD = 32'h7B4A4ABC;

  typedef enum logic {ST_DATA, ST_FILL} tx_state_e;

  function automatic logic is_align(input logic [DW-1:0] d, input logic k);
    return k && (d == ALIGN_WORD);
  endfunction
endpackage

// File: rtl/align_tx_ins.sv
module align_tx_ins
  import align_pacer_pkg::*;
#(
  parameter int GAP_W     = 8,
  parameter int GRP_SMALL = 2,
  parameter int GRP_LARGE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             cfg_quad,
  input  logic [DW-1:0]    in_data,
  input  logic             in_k,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_k,
  output logic             out_valid
);
  localparam int GC_W = $clog2(GRP_LARGE + 1);

  tx_state_e        state;
  logic [GAP_W-1:0] gap_cnt;
  logic [GC_W-1:0]  grp_cnt;
  logic [GC_W-1:0]  grp_last;
  logic [GAP_W:0]   gap_lim;
  logic [GAP_W:0]   gap_nxt;
  logic             take;

  assign in_ready = (state == ST_DATA);
  assign take     = in_valid && in_ready;
  assign gap_lim  = (cfg_gap == '0) ? (GAP_W+1)'(1) : {1'b0, cfg_gap};
  assign gap_nxt  = {1'b0, gap_cnt} + (GAP_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_DATA;
      gap_cnt   <= '0;
      grp_cnt   <= '0;
      grp_last  <= '0;
      out_data  <= '0;
      out_k     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      case (state)
        ST_DATA: begin
          out_valid <= take;
          if (take) begin
            out_data <= in_data;
            out_k    <= in_k;
            if (!is_align(in_data, in_k)) begin
              if (gap_nxt >= gap_lim) begin
                state    <= ST_FILL;
                gap_cnt  <= '0;
                grp_cnt  <= '0;
                grp_last <= cfg_quad ? GC_W'(GRP_LARGE - 1) : GC_W'(GRP_SMALL - 1);
              end else begin
                gap_cnt <= gap_nxt[GAP_W-1:0];
              end
            end
          end
        end
        default: begin
          out_valid <= 1'b1;
          out_data  <= ALIGN_WORD;
          out_k     <= 1'b1;
          grp_cnt   <= grp_cnt + GC_W'(1);
          if (grp_cnt == grp_last) state <= ST_DATA;
        end
      endcase
    end
  end
endmodule

// File: rtl/align_rx_strip.sv
module align_rx_strip
  import align_pacer_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  input  logic          in_k,
  input  logic          in_valid,
  output logic [DW-1:0] out_data,
  output logic          out_k,
  output logic          out_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_k     <= 1'b0;
    end else begin
      out_valid <= in_valid && !is_align(in_data, in_k);
      out_data  <= in_data;
      out_k     <= in_k;
    end
  end
endmodule

// File: rtl/align_pacer.sv
module align_pacer
  import align_pacer_pkg::*;
#(
  parameter int GAP_W     = 8,
  parameter int GRP_SMALL = 2,
  parameter int GRP_LARGE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             cfg_quad,
  input  logic [31:0]      tx_in_data,
  input  logic             tx_in_k,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  output logic [31:0]      tx_out_data,
  output logic             tx_out_k,
  output logic             tx_out_valid,
  input  logic [31:0]      rx_in_data,
  input  logic             rx_in_k,
  input  logic             rx_in_valid,
  output logic [31:0]      rx_out_data,
  output logic             rx_out_k,
  output logic             rx_out_valid
);
  align_tx_ins #(
    .GAP_W(GAP_W), .GRP_SMALL(GRP_SMALL), .GRP_LARGE(GRP_LARGE)
  ) u_tx (
    .clk(clk), .rst(rst), .cfg_gap(cfg_gap), .cfg_quad(cfg_quad),
    .in_data(tx_in_data), .in_k(tx_in_k), .in_valid(tx_in_valid),
    .in_ready(tx_in_ready), .out_data(tx_out_data), .out_k(tx_out_k),
    .out_valid(tx_out_valid)
  );

  align_rx_strip u_rx (
    .clk(clk), .rst(rst),
    .in_data(rx_in_data), .in_k(rx_in_k), .in_valid(rx_in_valid),
    .out_data(rx_out_data), .out_k(rx_out_k), .out_valid(rx_out_valid)
  );
endmodule

// File: rtl/align_pacer_chk.sv
module align_pacer_chk
  import align_pacer_pkg::*;
#(
  parameter int GRP_SMALL = 2,
  parameter int GRP_LARGE = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        cfg_quad,
  input logic [31:0] tx_in_data,
  input logic        tx_in_k,
  input logic        tx_in_valid,
  input logic        tx_in_ready,
  input logic [31:0] tx_out_data,
  input logic        tx_out_k,
  input logic        tx_out_valid,
  input logic [31:0] rx_in_data,
  input logic        rx_in_k,
  input logic        rx_in_valid,
  input logic [31:0] rx_out_data,
  input logic        rx_out_k,
  input logic        rx_out_valid
);
  localparam int RW = $clog2(GRP_LARGE + 1);
  logic [RW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else if (!tx_in_ready) low_run <= low_run + RW'(1);
    else low_run <= '0;
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    tx_in_valid && tx_in_ready |=> tx_out_valid && tx_out_data == $past(tx_in_data)
      && tx_out_k == $past(tx_in_k)); // R2

  AST_HOLD_EMITS_ALIGN: assert property (@(posedge clk) disable iff (rst)
    !tx_in_ready |=> tx_out_valid && tx_out_k && tx_out_data == ALIGN_WORD); // R5

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    tx_in_ready && !tx_in_valid |=> !tx_out_valid); // R6

  AST_GROUP_BOUND: assert property (@(posedge clk) disable iff (rst)
    !tx_in_ready |-> low_run < RW'(GRP_LARGE)); // R4

  AST_GROUP_SIZE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_in_ready) |-> low_run == (cfg_quad ? RW'(GRP_LARGE) : RW'(GRP_SMALL))); // R4

  AST_RX_NO_ALIGN: assert property (@(posedge clk) disable iff (rst)
    rx_out_valid |-> !is_align(rx_out_data, rx_out_k)); // R8

  AST_RX_FORWARD: assert property (@(posedge clk) disable iff (rst)
    rx_in_valid && !is_align(rx_in_data, rx_in_k) |=> rx_out_valid
      && rx_out_data == $past(rx_in_data) && rx_out_k == $past(rx_in_k)); // R9
endmodule

bind align_pacer align_pacer_chk #(.GRP_SMALL(GRP_SMALL), .GRP_LARGE(GRP_LARGE)) u_chk (
  .clk(clk), .rst(rst), .cfg_quad(cfg_quad),
  .tx_in_data(tx_in_data), .tx_in_k(tx_in_k), .tx_in_valid(tx_in_valid),
  .tx_in_ready(tx_in_ready), .tx_out_data(tx_out_data), .tx_out_k(tx_out_k),
  .tx_out_valid(tx_out_valid), .rx_in_data(rx_in_data), .rx_in_k(rx_in_k),
  .rx_in_valid(rx_in_valid), .rx_out_data(rx_out_data), .rx_out_k(rx_out_k),
  .rx_out_valid(rx_out_valid)
);

// File: tb/align_pacer_test.sv
`timescale 1ns/1ps
module align_pacer_test;
  localparam logic [31:0] AW   = 32'h7B4A4ABC;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam int NCYC = 600;
  localparam int NV = 7;
  localparam logic [8:0] VECS [NV] = '{
    {8'd254, 1'b0}, {8'd254, 1'b1}, {8'd1, 1'b0}, {8'd1, 1'b1},
    {8'd0, 1'b0},   {8'd3, 1'b1},   {8'd7, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] cfg_gap = 8'd254;
  logic cfg_quad = 1'b0;
  logic [31:0] tx_in_data = '0;
  logic tx_in_k = 1'b0, tx_in_valid = 1'b0;
  logic tx_in_ready;
  logic [31:0] tx_out_data, rx_out_data;
  logic tx_out_k, tx_out_valid, rx_out_k, rx_out_valid;
  logic lb = 1'b1;
  logic [31:0] rd_data = '0;
  logic rd_k = 1'b0, rd_valid = 1'b0;
  logic [31:0] rx_in_data;
  logic rx_in_k, rx_in_valid;

  assign rx_in_data  = lb ? tx_out_data  : rd_data;
  assign rx_in_k     = lb ? tx_out_k     : rd_k;
  assign rx_in_valid = lb ? tx_out_valid : rd_valid;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  align_pacer uut (
    .clk(clk), .rst(rst), .cfg_gap(cfg_gap), .cfg_quad(cfg_quad),
    .tx_in_data(tx_in_data), .tx_in_k(tx_in_k), .tx_in_valid(tx_in_valid),
    .tx_in_ready(tx_in_ready), .tx_out_data(tx_out_data), .tx_out_k(tx_out_k),
    .tx_out_valid(tx_out_valid), .rx_in_data(rx_in_data), .rx_in_k(rx_in_k),
    .rx_in_valid(rx_in_valid), .rx_out_data(rx_out_data), .rx_out_k(rx_out_k),
    .rx_out_valid(rx_out_valid)
  );

  task automatic chk(input logic ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // capture of the valid output stream (0: transmit, 1: receive)
  logic cap_on = 1'b0, cap_sel = 1'b0;
  logic [32:0] cap [32];
  int ncap = 0;
  always @(negedge clk) begin
    if (cap_on && ncap < 32) begin
      if (!cap_sel && tx_out_valid) begin cap[ncap] = {tx_out_k, tx_out_data}; ncap++; end
      if (cap_sel && rx_out_valid)  begin cap[ncap] = {rx_out_k, rx_out_data}; ncap++; end
    end
  end

  task automatic do_reset(input logic [7:0] g, input logic q);
    @(negedge clk);
    rst = 1'b1; cfg_gap = g; cfg_quad = q; tx_in_valid = 1'b0; rd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input logic [31:0] d, input logic k);
    tx_in_valid = 1'b1; tx_in_data = d; tx_in_k = k;
    while (!tx_in_ready) @(negedge clk);
    @(negedge clk);
    tx_in_valid = 1'b0;
  endtask

  task automatic run_vec(input logic [7:0] g, input logic q);
    int ge, grp, per, pos, tseq, rseq;
    logic acc;
    ge = (g == 0) ? 1 : int'(g);
    grp = q ? 4 : 2;
    per = ge + grp;
    pos = 0; tseq = 0; rseq = 0; acc = 1'b0;
    lb = 1'b1;
    do_reset(g, q);
    for (int c = 0; c < NCYC + 3; c++) begin
      if (c > 0) @(negedge clk);
      if (acc) tseq = tseq;
      if (c >= 1 && c <= NCYC)
        chk(tx_out_valid, "R3 continuous output", {32'd0, tx_out_valid}, 33'd1);
      if (tx_out_valid) begin
        if ((pos % per) < ge) begin
          chk(!tx_out_k && tx_out_data == BASE + 32'(tseq), "R2/R3 data slot",
              {tx_out_k, tx_out_data}, {1'b0, BASE + 32'(tseq)});
          tseq++;
        end else begin
          chk(tx_out_k && tx_out_data == AW, (g == 0) ? "R10 align slot" : "R3/R4 align slot",
              {tx_out_k, tx_out_data}, {1'b1, AW});
        end
        pos++;
      end
      if (rx_out_valid) begin
        chk(!rx_out_k && rx_out_data == BASE + 32'(rseq), "R11 loopback order",
            {rx_out_k, rx_out_data}, {1'b0, BASE + 32'(rseq)});
        rseq++;
      end
      if (c < NCYC) begin
        chk(tx_in_ready == ((pos % per) < ge), "R5 ready", {32'd0, tx_in_ready},
            {32'd0, ((pos % per) < ge)});
        tx_in_valid = 1'b1; tx_in_k = 1'b0;
        tx_in_data = BASE + 32'(pos - (pos / per) * grp - ((pos % per) < ge ? 0 : (pos % per) - ge));
        acc = tx_in_ready;
      end else begin
        tx_in_valid = 1'b0;
      end
    end
    chk(rseq == tseq, "R11 loss-free", 33'(rseq), 33'(tseq));
  endtask

  logic [32:0] exp_s [8];

  initial begin : main
    // reset state
    do_reset(8'd254, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk(!tx_out_valid && !rx_out_valid && tx_in_ready, "R1 reset state",
        {30'd0, tx_out_valid, rx_out_valid, tx_in_ready}, 33'd1);
    rst = 1'b0;

    // table of interval / group-size vectors
    for (int v = 0; v < NV; v++) run_vec(VECS[v][8:1], VECS[v][0]);

    // R6: idle cycles do not advance the interval
    lb = 1'b1;
    do_reset(8'd3, 1'b0);
    ncap = 0; cap_sel = 1'b0; cap_on = 1'b1;
    send(32'hA0, 1'b0); send(32'hA1, 1'b0);
    repeat (6) begin
      @(negedge clk);
      chk(!tx_out_valid, "R6 idle output", {32'd0, tx_out_valid}, 33'd0);
    end
    send(32'hA2, 1'b0); send(32'hA3, 1'b0);
    repeat (4) @(negedge clk);
    cap_on = 1'b0;
    exp_s[0] = {1'b0, 32'hA0}; exp_s[1] = {1'b0, 32'hA1}; exp_s[2] = {1'b0, 32'hA2};
    exp_s[3] = {1'b1, AW};     exp_s[4] = {1'b1, AW};     exp_s[5] = {1'b0, 32'hA3};
    chk(ncap == 6, "R6 stream length", 33'(ncap), 33'd6);
    for (int i = 0; i < 6; i++) chk(cap[i] == exp_s[i], "R6 stream word", cap[i], exp_s[i]);

    // R7: upstream ALIGN passes, not counted
    do_reset(8'd2, 1'b1);
    ncap = 0; cap_sel = 1'b0; cap_on = 1'b1;
    send(32'hB0, 1'b0); send(AW, 1'b1); send(32'hB1, 1'b0); send(32'hB2, 1'b0);
    repeat (4) @(negedge clk);
    cap_on = 1'b0;
    exp_s[0] = {1'b0, 32'hB0}; exp_s[1] = {1'b1, AW}; exp_s[2] = {1'b0, 32'hB1};
    for (int i = 3; i < 7; i++) exp_s[i] = {1'b1, AW};
    exp_s[7] = {1'b0, 32'hB2};
    chk(ncap == 8, "R7 stream length", 33'(ncap), 33'd8);
    for (int i = 0; i < 8; i++) chk(cap[i] == exp_s[i], "R7 stream word", cap[i], exp_s[i]);

    // R8/R9: receive filter, driven directly
    lb = 1'b0;
    do_reset(8'd254, 1'b0);
    ncap = 0; cap_sel = 1'b1; cap_on = 1'b1;
    rd_valid = 1'b1; rd_data = 32'hC0; rd_k = 1'b0;
    @(negedge clk);
    chk(rx_out_valid && rx_out_data == 32'hC0, "R9 one-cycle latency",
        {rx_out_valid, rx_out_data}, {1'b1, 32'hC0});
    rd_data = AW;      rd_k = 1'b1; @(negedge clk);
    chk(!rx_out_valid, "R8 align dropped", {32'd0, rx_out_valid}, 33'd0);
    rd_data = AW;      rd_k = 1'b0; @(negedge clk);
    rd_data = 32'hBC;  rd_k = 1'b1; @(negedge clk);
    rd_valid = 1'b0;   rd_data = 32'hDD; rd_k = 1'b0; @(negedge clk);
    rd_valid = 1'b1;   rd_data = AW; rd_k = 1'b1; @(negedge clk);
    rd_data = 32'hC1;  rd_k = 1'b0; @(negedge clk);
    rd_valid = 1'b0;
    repeat (2) @(negedge clk);
    cap_on = 1'b0;
    exp_s[0] = {1'b0, 32'hC0}; exp_s[1] = {1'b0, AW}; exp_s[2] = {1'b1, 32'hBC};
    exp_s[3] = {1'b0, 32'hC1};
    chk(ncap == 4, "R8/R9 stream length", 33'(ncap), 33'd4);
    for (int i = 0; i < 4; i++) chk(cap[i] == exp_s[i], "R9 stream word", cap[i], exp_s[i]);

    // R1: reset in the middle of a group
    lb = 1'b1;
    do_reset(8'd1, 1'b1);
    send(32'hE0, 1'b0);
    chk(!tx_in_ready, "R5 group in progress", {32'd0, tx_in_ready}, 33'd0);
    rst = 1'b1;
    @(negedge clk);
    chk(!tx_out_valid && !rx_out_valid && tx_in_ready, "R1 reset mid-group",
        {30'd0, tx_out_valid, rx_out_valid, tx_in_ready}, 33'd1);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule